// File: doc/BRIEF.md
# Per-Pin Serial Name Beacon

This block drives a set of FPGA output pins, each with a label of its own, so that an unknown package pin can be found on a board. Each pin carries a free-running asynchronous serial transmitter. That transmitter sends the pin's label as ASCII text, followed by a carriage return and a line feed, and then repeats without end. An engineer connects a serial receiver to a probe and touches board pads. When the terminal shows a label, that pad belongs to the pin with that label.

All transmitters are driven by one shared bit-rate tick, which is derived from the clock frequency and the baud rate given as parameters. Each transmitter has its own character position and bit position, so labels of different lengths repeat on their own schedules. The labels are fixed at elaboration in one packed parameter table. The number of transmitters is a parameter.

Top module: `pin_beacon_array`

## Requirements
- R1: While `rst` is high, and after its release until the first bit-rate tick, every `tx_o` line stays high (idle). The first start bit comes about one bit period after release.
- R2: A bit period lasts round(CLK_HZ / BAUD) clocks. The start bits of consecutive characters on a line are exactly ten bit periods apart.
- R3: Each character is one low start bit, then eight data bits with the least significant bit first, then one high stop bit.
- R4: Line p sends only its own label, with the characters in order from the first.
- R5: After the last label character, the line sends 0x0D and then 0x0A, and then restarts at the first character with no idle time between frames.
- R6: Label p sits in `NAME_TABLE` bits [(p*MAX_LEN+k)*8 +: 8] for character k. A 0x00 byte ends a label that is shorter than MAX_LEN. Labels of different lengths repeat with their own period (length+2 frames).
- R7: All lines take their timing from one shared tick, so after reset their start bits fall in the same clock cycle.
- R8: Asserting `rst` in the middle of a frame returns every line to the first character of its label. The line stays idle high until transmission starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| tx_o | output | NUM_PINS | One serial line per labelled pin, bit p for label p |

## Verification
If a character index is wrong, a receiver sees the wrong byte or a missing CR/LF within one frame, which is ten bit periods. If a bit counter is off, a start bit moves away from its ten-period slot or a stop bit reads low within one frame. A fault in the shared divider changes the spacing of every line's start bits on the very first character. A reset fault shows as a first character after release that is not the start of the label.

// File: rtl/beacon_pkg.sv
`timescale 1ns/1ps
package beacon_pkg;
  typedef logic [7:0] char_t;

  localparam char_t ASCII_CR = 8'h0D;
  localparam char_t ASCII_LF = 8'h0A;

  // Clocks per serial bit, rounded to nearest.
  function automatic int clocks_per_bit(input longint clk_hz, input longint baud);
    return int'((clk_hz + baud / 2) / baud);
  endfunction
endpackage

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen #(
  parameter int DIV = 434
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == CNT_LAST) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST); // R2
  AST_TICK_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> cnt == '0); // R2
endmodule

// File: rtl/name_sequencer.sv
`timescale 1ns/1ps
module name_sequencer
  import beacon_pkg::*;
#(
  parameter int MAX_LEN = 4,
  parameter logic [MAX_LEN*8-1:0] NAME = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv_i,
  output char_t char_o
);
  function automatic int count_chars();
    int  n    = 0;
    bit  done = 1'b0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (!done && NAME[k*8 +: 8] != 8'h00) n++;
      else done = 1'b1;
    end
    return n;
  endfunction

  localparam int LEN   = count_chars();
  localparam int SLOTS = LEN + 2;
  localparam int IW    = $clog2(SLOTS);
  localparam logic [IW-1:0] IDX_LAST = IW'(SLOTS - 1);

  char_t         msg [SLOTS];
  logic [IW-1:0] idx;

  for (genvar k = 0; k < LEN; k++) begin : g_chr
    assign msg[k] = NAME[k*8 +: 8];
  end
  assign msg[LEN]     = ASCII_CR;
  assign msg[LEN + 1] = ASCII_LF;

  always_ff @(posedge clk) begin
    if (rst)        idx <= '0;
    else if (adv_i) idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
  end

  assign char_o = msg[idx];

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_LAST); // R5
  AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (rst)
    (adv_i && char_o == ASCII_LF && idx == IDX_LAST) |=> char_o == msg[0]); // R5
  AST_RESET_FIRST: assert property (@(posedge clk)
    rst |=> idx == '0); // R8
endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import beacon_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_i,
  input  char_t char_i,
  output logic  take_o,
  output logic  tx_o
);
  localparam logic [3:0] STOP_POS = 4'd9;

  logic [3:0] bit_cnt;
  logic [8:0] shreg;

  assign take_o = tick_i && (bit_cnt == STOP_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= STOP_POS;
      shreg   <= '1;
      tx_o    <= 1'b1;
    end else if (take_o) begin
      bit_cnt <= '0;
      shreg   <= {1'b1, char_i};
      tx_o    <= 1'b0;
    end else if (tick_i) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= {1'b1, shreg[8:1]};
      tx_o    <= shreg[0];
    end
  end

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    rst |=> tx_o); // R1
  AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_i) |-> $stable(tx_o)); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !tx_o); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    bit_cnt == STOP_POS |-> tx_o); // R3
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= STOP_POS); // R3
endmodule

// File: rtl/pin_beacon_array.sv
`timescale 1ns/1ps
module pin_beacon_array
  import beacon_pkg::*;
#(
  parameter longint CLK_HZ   = 125_000_000,
  parameter longint BAUD     = 115_200,
  parameter int     NUM_PINS = 4,
  parameter int     MAX_LEN  = 4,
  parameter logic [NUM_PINS*MAX_LEN*8-1:0] NAME_TABLE =
    {32'h3632_5641, 32'h3632_5741, 32'h0030_3142, 32'h0030_3141}
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_PINS-1:0] tx_o
);
  localparam int DIV   = clocks_per_bit(CLK_HZ, BAUD);
  localparam int SLICE = MAX_LEN * 8;

  logic bit_tick;

  baud_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (bit_tick)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    char_t cur_char;
    logic  take;

    name_sequencer #(
      .MAX_LEN (MAX_LEN),
      .NAME    (NAME_TABLE[p*SLICE +: SLICE])
    ) u_seq (
      .clk    (clk),
      .rst    (rst),
      .adv_i  (take),
      .char_o (cur_char)
    );

    uart_frame_tx u_tx (
      .clk    (clk),
      .rst    (rst),
      .tick_i (bit_tick),
      .char_i (cur_char),
      .take_o (take),
      .tx_o   (tx_o[p])
    );
  end
endmodule

// File: tb/tb_pin_beacon_array.sv
`timescale 1ns/1ps
module tb_pin_beacon_array;
  localparam int NP      = 4;
  localparam int MAXL    = 4;
  localparam int BIT_CYC = 434;   // round(50e6 / 115200)

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] tx;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  string        names [NP] = '{"A10", "B10", "AW26", "AV26"};
  byte unsigned exp_q [NP][$];
  int           first_fall [NP];

  pin_beacon_array #(
    .CLK_HZ     (50_000_000),
    .BAUD       (115_200),
    .NUM_PINS   (NP),
    .MAX_LEN    (MAXL),
    .NAME_TABLE ({32'h3632_5641, 32'h3632_5741, 32'h0030_3142, 32'h0030_3141})
  ) dut (
    .clk  (clk),
    .rst  (rst),
    .tx_o (tx)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // driver: push expected characters (label then CR LF) per repetition
  task automatic push_name(input int p, input int reps);
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k < names[p].len(); k++) exp_q[p].push_back(names[p][k]);
      exp_q[p].push_back(8'h0D);
      exp_q[p].push_back(8'h0A);
    end
  endtask

  // monitor: decode frames on one line and compare against the queue
  task automatic monitor(input int p, input int frames, input bit after_rst);
    int start_c;
    int prev_c;
    byte unsigned got;
    byte unsigned exp;
    string tag;
    do @(negedge clk); while (tx[p] !== 1'b0);
    start_c = cyc;
    first_fall[p] = cyc;
    for (int f = 0; f < frames; f++) begin
      if (f > 0) check(start_c - prev_c == 10 * BIT_CYC, "R2 R5 spacing",
                       start_c - prev_c, 10 * BIT_CYC);
      repeat (BIT_CYC / 2) @(negedge clk);
      check(tx[p] == 1'b0, "R3 start", int'(tx[p]), 0);
      got = '0;
      for (int b = 0; b < 8; b++) begin
        repeat (BIT_CYC) @(negedge clk);
        got[b] = tx[p];
      end
      repeat (BIT_CYC) @(negedge clk);
      check(tx[p] == 1'b1, "R3 stop", int'(tx[p]), 1);
      exp = exp_q[p].pop_front();
      if (after_rst && f == 0)            tag = "R8 first char";
      else if (exp == 8'h0D || exp == 8'h0A) tag = "R5 CR/LF";
      else if (names[p].len() < MAXL)     tag = "R6 short label";
      else                                tag = "R4 label";
      check(got == exp, tag, got, exp);
      if (f < frames - 1) begin
        prev_c = start_c;
        do @(negedge clk); while (tx[p] !== 1'b0);
        start_c = cyc;
      end
    end
  endtask

  task automatic run_all(input int reps, input bit after_rst);
    for (int p = 0; p < NP; p++) push_name(p, reps);
    for (int p = 0; p < NP; p++) begin
      automatic int pp = p;
      fork
        monitor(pp, reps * (names[pp].len() + 2), after_rst);
      join_none
    end
    wait fork;
    for (int p = 0; p < NP; p++)
      check(exp_q[p].size() == 0, "R4 queue drained", exp_q[p].size(), 0);
  endtask

  initial begin : watchdog
    wait (cyc > 190_000);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int rel;
    repeat (5) @(negedge clk);
    check(tx == '1, "R1 idle in reset", tx, {NP{1'b1}});
    rst = 1'b0;
    rel = cyc;
    @(negedge clk);
    check(tx == '1, "R1 idle after release", tx, {NP{1'b1}});

    run_all(2, 1'b0);
    for (int p = 0; p < NP; p++) begin
      check(first_fall[p] >= rel + BIT_CYC - 1 && first_fall[p] <= rel + BIT_CYC + 3,
            "R1 first start delay", first_fall[p] - rel, BIT_CYC);
      check(first_fall[p] == first_fall[0], "R7 aligned starts",
            first_fall[p], first_fall[0]);
    end

    // reset in the middle of running frames
    repeat (1000) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(tx == '1, "R8 idle during mid-frame reset", tx, {NP{1'b1}});
    rst = 1'b0;
    rel = cyc;
    run_all(1, 1'b1);
    for (int p = 0; p < NP; p++)
      check(first_fall[p] == first_fall[0], "R7 aligned after reset",
            first_fall[p], first_fall[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule